// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses from the codecs on a link and stores each one in a circular buffer in system memory. Every entry is eight bytes long. The low dword carries the 32-bit response word. The high dword tags the entry with the codec address and a flag that marks the response as unsolicited. The block owns the ring's write pointer. It also counts the entries written since the last interrupt request and raises a sticky status flag when that count reaches a programmed threshold, provided interrupts are enabled.

Software programs a ring-size code, a base address, a threshold and a control word through a simple register write port. Setting the enable bit captures the size and the base, and the ring then runs from the current write pointer. Each entry leaves the block as two dword writes on a valid/ready memory port: the response word first, then the tag word. Merging this flag with other interrupt sources is done elsewhere.

Top module: `rring_writer`

## Requirements
- R1: The size code (register 1, bits 1:0) selects 2, 16 or 256 entries for codes 0, 1 and 2. When code 3 is held, writing the enable bit (register 0, bit 0) leaves the ring inactive (`active_o` low).
- R2: The entry with index i is written at base + 8*i. The first beat is the response word at offset 0 and the second beat is the tag word at offset 4. The base comes from register 2 with bits 2:0 forced to zero.
- R3: The tag word holds the codec address in bits 3:0 and the unsolicited flag in bit 4. All higher bits are zero.
- R4: Each accepted response targets index (wp+1) modulo the ring size. `wp_o` takes that index on the cycle after the second beat is accepted.
- R5: An entry counter counts the completed entries. When the incremented count equals the threshold (register 3, bits 7:0), the count is nonzero, and interrupt enable (register 0, bit 1) is set, `irq_o` is set and the counter returns to zero. Otherwise the counter keeps counting and wraps at 256. A zero threshold therefore never raises the flag.
- R6: `irq_o` stays set until software writes 1 to bit 0 of register 4. Writing 0 there leaves the flag unchanged.
- R7: A rising enable captures the size code and the base. Later writes to those registers have no effect until the next enable. Clearing enable abandons any entry in flight and zeroes the counter, while `wp_o` keeps its value.
- R8: While the ring is inactive, `rsp_ready` is high, responses are discarded, and no memory beat is issued. While an entry is being written, `rsp_ready` is low.
- R9: Once `mem_valid` is high, it stays high with a stable address and data until `mem_ready` is seen, unless the ring is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0 control, 1 size, 2 base, 3 threshold, 4 status clear) |
| reg_wdata | input | 32 | Register write data |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response taken (or discarded) this cycle |
| rsp_data | input | 32 | Response word |
| rsp_cad | input | 4 | Codec address of the response |
| rsp_unsol | input | 1 | Response is unsolicited |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Dword written by the beat |
| wp_o | output | 8 | Index of the last completed entry |
| irq_o | output | 1 | Sticky response interrupt flag |
| active_o | output | 1 | Ring enabled |

## Verification
The bench wraps the pointer through the 2-entry ring and the full 256-entry ring. A design that masked the pointer by the wrong size, or advanced it after computing the address, would write the wrong slots. It changes the size register while the ring runs, which exposes a design that does not latch its configuration. It also disables the ring while a beat is stalled, which catches a design that still commits the pointer or keeps driving the memory port. It drives the threshold to 3 with interrupts on, and then to 0 across a counter wrap. This separates a correct flag from one that never fires or one that fires when the counter wraps through zero.

// File: rtl/rring_pkg.sv
package rring_pkg;

    localparam int unsigned PTR_W = 8;
    localparam int unsigned CNT_W = 8;

    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_SIZE = 3'd1;
    localparam logic [2:0] REG_BASE = 3'd2;
    localparam logic [2:0] REG_THR  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    localparam logic [1:0] SIZE_BAD = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } beat_e;

    // index mask for a size code: 2, 16 or 256 entries
    function automatic logic [PTR_W-1:0] ring_mask(input logic [1:0] code);
        case (code)
            2'd0:    return PTR_W'(1);
            2'd1:    return PTR_W'(15);
            default: return PTR_W'(255);
        endcase
    endfunction

endpackage

// File: rtl/rring_regs.sv
module rring_regs
    import rring_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             active,
    output logic             int_en,
    output logic [CNT_W-1:0] thr,
    output logic [AW-1:0]    base_lat,
    output logic [1:0]       size_lat,
    output logic             stat_clr
);

    typedef struct packed {
        logic             active;
        logic             int_en;
        logic [1:0]       size;
        logic [AW-1:0]    base;
        logic [CNT_W-1:0] thr;
        logic [1:0]       size_lat;
        logic [AW-1:0]    base_lat;
    } regs_s;

    regs_s q, d;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        d        = q;
        stat_clr = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                REG_CTRL: begin
                    d.int_en = reg_wdata[1];
                    if (reg_wdata[0]) begin
                        if (!q.active && (q.size != SIZE_BAD)) begin
                            d.active   = 1'b1;
                            d.size_lat = q.size;
                            d.base_lat = {q.base[AW-1:3], 3'b000};
                        end
                    end else begin
                        d.active = 1'b0;
                    end
                end
                REG_SIZE: d.size     = reg_wdata[1:0];
                REG_BASE: d.base     = reg_wdata[AW-1:0];
                REG_THR:  d.thr      = reg_wdata[CNT_W-1:0];
                REG_STAT: stat_clr   = reg_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active   = q.active;
    assign int_en   = q.int_en;
    assign thr      = q.thr;
    assign base_lat = q.base_lat;
    assign size_lat = q.size_lat;

endmodule

// File: rtl/rring_seq.sv
module rring_seq
    import rring_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned CAD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             int_en,
    input  logic [CNT_W-1:0] thr,
    input  logic [AW-1:0]    base,
    input  logic [1:0]       size_code,
    input  logic             stat_clr,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [DW-1:0]    rsp_data,
    input  logic [CAD_W-1:0] rsp_cad,
    input  logic             rsp_unsol,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [PTR_W-1:0] wp,
    output logic             irq_flag
);

    localparam int unsigned PAD_W = DW - CAD_W - 1;

    typedef struct packed {
        beat_e            st;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    dat;
        logic [DW-1:0]    ext;
        logic             flag;
    } seq_s;

    seq_s             q, d;
    logic             fire;
    logic [CNT_W-1:0] cnt_inc;
    logic [PTR_W-1:0] mask;

    assign mask    = ring_mask(size_code);
    assign cnt_inc = q.cnt + CNT_W'(1);

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (!active) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_IDLE: if (rsp_valid) begin
                    d.idx = (q.wp + PTR_W'(1)) & mask;
                    d.dat = rsp_data;
                    d.ext = {{PAD_W{1'b0}}, rsp_unsol, rsp_cad};
                    d.st  = ST_LO;
                end
                ST_LO: if (mem_ready) d.st = ST_HI;
                ST_HI: if (mem_ready) begin
                    d.st = ST_IDLE;
                    d.wp = q.idx;
                    if ((cnt_inc == thr) && int_en && (cnt_inc != '0)) begin
                        fire  = 1'b1;
                        d.cnt = '0;
                    end else begin
                        d.cnt = cnt_inc;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
        d.flag = (q.flag & ~stat_clr) | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_ready = !active || (q.st == ST_IDLE);
    assign mem_valid = active && (q.st != ST_IDLE);
    assign mem_addr  = base + AW'({q.idx, 3'b000})
                     + ((q.st == ST_HI) ? AW'(4) : AW'(0));
    assign mem_wdata = (q.st == ST_HI) ? q.ext : q.dat;
    assign wp        = q.wp;
    assign irq_flag  = q.flag;

endmodule

// File: rtl/rring_writer.sv
module rring_writer
    import rring_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned CAD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [DW-1:0]    rsp_data,
    input  logic [CAD_W-1:0] rsp_cad,
    input  logic             rsp_unsol,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [PTR_W-1:0] wp_o,
    output logic             irq_o,
    output logic             active_o
);

    logic             int_en;
    logic [CNT_W-1:0] thr;
    logic [AW-1:0]    base_lat;
    logic [1:0]       lat_size;
    logic             stat_clr;

    rring_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .active    (active_o),
        .int_en    (int_en),
        .thr       (thr),
        .base_lat  (base_lat),
        .size_lat  (lat_size),
        .stat_clr  (stat_clr)
    );

    rring_seq #(.AW(AW), .DW(DW), .CAD_W(CAD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active_o),
        .int_en    (int_en),
        .thr       (thr),
        .base      (base_lat),
        .size_code (lat_size),
        .stat_clr  (stat_clr),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_cad   (rsp_cad),
        .rsp_unsol (rsp_unsol),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .wp        (wp_o),
        .irq_flag  (irq_o)
    );

endmodule

// File: rtl/rring_chk.sv
module rring_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          rsp_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [7:0]    wp_o,
    input logic          irq_o,
    input logic          active_o,
    input logic [1:0]    lat_size
);

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !(reg_we && reg_addr == 3'd0))
        |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !rsp_ready); // R8

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (rsp_ready && !mem_valid)); // R8

    AST_TAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_addr[2]) |-> (mem_wdata[DW-1:5] == '0)); // R3

    AST_WP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wp_o) |-> $past(mem_valid && mem_ready && mem_addr[2])); // R4

    AST_FLAG_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mem_valid && mem_ready && mem_addr[2])); // R5

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (lat_size != 2'd3)); // R1

endmodule

bind rring_writer rring_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .rsp_ready (rsp_ready),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wp_o      (wp_o),
    .irq_o     (irq_o),
    .active_o  (active_o),
    .lat_size  (lat_size)
);

// File: tb/tb_rring_writer.sv
module tb_rring_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_data = 32'd0;
    logic [3:0]  rsp_cad = 4'd0;
    logic        rsp_unsol = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [7:0]  wp_o;
    logic        irq_o;
    logic        active_o;

    always #4 clk = ~clk;

    rring_writer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_cad(rsp_cad), .rsp_unsol(rsp_unsol),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wp_o(wp_o), .irq_o(irq_o), .active_o(active_o)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int rdy_mode = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_active, m_int, m_size_reg, m_entries, m_thr, m_wp, m_cnt, m_flag, m_pidx;
    longint m_base_reg, m_base;
    longint qa[$];
    longint qd[$];

    function automatic int entries_of(input int code);
        if (code == 0) return 2;
        if (code == 1) return 16;
        return 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_int = 0; m_size_reg = 0; m_entries = 2; m_thr = 0;
            m_wp = 0; m_cnt = 0; m_flag = 0; m_pidx = 0; m_base_reg = 0; m_base = 0;
            qa.delete(); qd.delete();
        end else begin
            int c;
            bit fire;
            bit busy;
            fire = 0;
            busy = (qa.size() != 0);
            if (m_active == 0) begin
                qa.delete(); qd.delete(); m_cnt = 0;
            end else if (busy) begin
                if (mem_ready) begin
                    void'(qa.pop_front()); void'(qd.pop_front());
                    if (qa.size() == 0) begin
                        m_wp = m_pidx;
                        c = (m_cnt + 1) % 256;
                        if (c == m_thr && m_int != 0 && c != 0) begin fire = 1; m_cnt = 0; end
                        else m_cnt = c;
                    end
                end
            end else if (rsp_valid) begin
                m_pidx = (m_wp + 1) % m_entries;
                qa.push_back(m_base + 8 * m_pidx);
                qd.push_back(longint'(rsp_data));
                qa.push_back(m_base + 8 * m_pidx + 4);
                qd.push_back(longint'(rsp_cad) + (rsp_unsol ? 16 : 0));
            end
            if (reg_we && reg_addr == 3'd4 && reg_wdata[0]) m_flag = 0;
            if (fire) m_flag = 1;
            if (reg_we) begin
                case (reg_addr)
                    3'd0: begin
                        m_int = reg_wdata[1];
                        if (reg_wdata[0]) begin
                            if (m_active == 0 && m_size_reg != 3) begin
                                m_active = 1;
                                m_entries = entries_of(m_size_reg);
                                m_base = m_base_reg - (m_base_reg % 8);
                            end
                        end else m_active = 0;
                    end
                    3'd1: m_size_reg = reg_wdata[1:0];
                    3'd2: m_base_reg = reg_wdata;
                    3'd3: m_thr = reg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: mem_ready = 1'b1;
            1: mem_ready = (cyc % 3) != 0;
            default: mem_ready = 1'b0;
        endcase
        if (rst_n && !done) begin
            bit ev;
            ev = (m_active != 0) && (qa.size() != 0);
            chk(rsp_ready == ((m_active == 0) || (qa.size() == 0)), "R8 ready", rsp_ready,
                (m_active == 0) || (qa.size() == 0));
            chk(mem_valid == ev, "R9 valid", mem_valid, ev);
            if (ev) begin
                chk(mem_addr == 32'(qa[0]), "R2 addr", mem_addr, qa[0]);
                chk(mem_wdata == 32'(qd[0]), "R3 data", mem_wdata, qd[0]);
            end
            chk(wp_o == 8'(m_wp), "R4 wp", wp_o, m_wp);
            chk(irq_o == m_flag[0], "R5 irq", irq_o, m_flag);
            chk(active_o == m_active[0], "R1 active", active_o, m_active);
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic send_rsp(input logic [31:0] v, input logic [3:0] cad, input logic un);
        bit r;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = v; rsp_cad = cad; rsp_unsol = un;
        forever begin
            r = rsp_ready;
            @(negedge clk);
            if (r) break;
        end
        rsp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(wp_o == 8'd0, "R4 reset wp", wp_o, 0);
        chk(irq_o == 1'b0, "R5 reset irq", irq_o, 0);
        chk(rsp_ready == 1'b1 && !mem_valid, "R8 reset idle", rsp_ready, 1);

        // R8: inactive ring discards responses
        send_rsp(32'hDEAD0001, 4'd2, 1'b0);
        settle();
        chk(wp_o == 8'd0, "R8 dropped wp", wp_o, 0);

        // R1: code 3 blocks enable
        wr_reg(3'd1, 32'd3);
        wr_reg(3'd0, 32'd1);
        settle();
        chk(active_o == 1'b0, "R1 bad size", active_o, 0);

        // 2-entry ring, base with low bits set (R2 alignment)
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd2, 32'h0000_1005);
        wr_reg(3'd0, 32'd1);
        chk(active_o == 1'b1, "R1 enable", active_o, 1);
        send_rsp(32'hA000_0001, 4'd1, 1'b0); settle();
        send_rsp(32'hA000_0002, 4'd15, 1'b1); settle();
        send_rsp(32'hA000_0003, 4'd7, 1'b1); settle();
        chk(wp_o == 8'd1, "R4 wrap of 2", wp_o, 1);

        // R7: size change while running has no effect
        wr_reg(3'd1, 32'd1);
        wr_reg(3'd2, 32'h0000_3000);
        send_rsp(32'hB000_0001, 4'd3, 1'b0); settle();
        chk(wp_o == 8'd0, "R7 size held", wp_o, 0);

        // re-enable as 16 entries, threshold 3, interrupts on, stalling memory
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd2, 32'h0000_2000);
        wr_reg(3'd3, 32'd3);
        wr_reg(3'd0, 32'd3);
        rdy_mode = 1;
        for (int i = 0; i < 5; i++) begin
            send_rsp(32'hC000_0000 + i, 4'(i), 1'(i));
            settle();
        end
        chk(wp_o == 8'd5, "R7 relatch size 16", wp_o, 5);
        chk(irq_o == 1'b1, "R5 threshold fires", irq_o, 1);
        wr_reg(3'd4, 32'd0);
        chk(irq_o == 1'b1, "R6 write zero keeps", irq_o, 1);
        wr_reg(3'd4, 32'd1);
        chk(irq_o == 1'b0, "R6 w1c clears", irq_o, 0);

        // R7: disable with a stalled beat abandons the entry
        rdy_mode = 2;
        send_rsp(32'hE000_0001, 4'd9, 1'b0);
        repeat (3) @(negedge clk);
        chk(mem_valid == 1'b1, "R9 stall holds", mem_valid, 1);
        wr_reg(3'd0, 32'd0);
        settle();
        chk(wp_o == 8'd5 && !mem_valid, "R7 abort keeps wp", wp_o, 5);
        rdy_mode = 0;

        // 256 entries, zero threshold with interrupts on: wrap, no flag
        wr_reg(3'd1, 32'd2);
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd0, 32'd3);
        for (int i = 0; i < 260; i++) begin
            send_rsp(32'h5000_0000 ^ (i * 32'h0101_0007), 4'(i * 5), 1'(i >> 1));
            repeat (3) @(negedge clk);
        end
        settle();
        chk(wp_o == 8'd9, "R4 wrap of 256", wp_o, 9);
        chk(irq_o == 1'b0, "R5 zero threshold", irq_o, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule